// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Controller

This block moves words between memory and peripherals for several independent channels, so the processor does not have to copy them. Software sets up each channel through a small register port. The setup gives a transfer direction, a repeat (circular) option, separate address-step options for the peripheral side and the memory side, a two-bit priority, an item count and two base addresses. A peripheral that wants an item moved raises its request line. The arbiter picks one channel. That channel then reads one word from its source and writes it to its destination through a simple request/acknowledge master port. After that the peripheral gets a one-cycle acknowledge, and the channel's count and addresses are updated.

When a channel finishes its count, its completion flag is set. When the master port returns an error, its error flag is set. Either flag can raise the interrupt line. Software clears flags by writing ones to a separate clear register.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: Register map: byte address bit 7 low selects channel space, with channel = addr[6:4] and register = addr[3:2] (0 control, 1 count, 2 peripheral address, 3 memory address). Control bits are [0] enable, [1] direction, [2] circular, [3] peripheral step, [4] memory step, [6:5] priority, [7] completion interrupt enable, [8] error interrupt enable. Count and address reads return the working values. Writes to count or address registers of an enabled channel are ignored.
- R2: Direction 0 reads from the memory address and writes to the peripheral address. Direction 1 reads from the peripheral address and writes to the memory address.
- R3: After each item, the peripheral working address grows by 4 only when its step bit is 1, and the memory working address grows by 4 only when its own step bit is 1.
- R4: The count drops by one per item. With circular off, the item that takes the count to zero clears the enable bit and sets the channel's completion flag.
- R5: With circular on, the item that takes the count to zero reloads the count and both working addresses from their programmed values, sets the completion flag and leaves the channel enabled.
- R6: Among enabled channels with a nonzero count and an active request, the highest priority (3 highest, 0 lowest) is granted. Ties go to the lower channel number.
- R7: No master-port activity happens without a request. Each item gives exactly one single-cycle acknowledge on the channel's acknowledge line, in the cycle after the write completes.
- R8: An error response on the master port clears that channel's enable bit, sets its error flag and gives no acknowledge. After a read error no write is issued.
- R9: Status at address 0x80 holds completion flags in bits [7:0] and error flags in bits [15:8], indexed by channel. Writing ones to 0x84 clears the matching flags. The interrupt is high while any flag is set whose interrupt enable is set.
- R10: Each item makes exactly one read and one write transaction. A request holds its address and write flag until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | NCH | Peripheral request lines |
| dack | output | NCH | Peripheral acknowledge pulses |
| m_req | output | 1 | Master transaction request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | AW | Master byte address |
| m_wdata | output | DW | Master write data |
| m_rdata | input | DW | Master read data |
| m_ack | input | 1 | Master transaction accepted/completed |
| m_err | input | 1 | Error response, valid with m_ack |
| irq | output | 1 | Interrupt |

## Verification
The bench goes after the wrap of a circular channel. A design that forgets to reload would leave the count at zero and stall, and one that forgets to reload the addresses would write past the buffer. It also covers a three-way request with a priority tie. A tie broken the wrong way, or a plain lowest-index arbiter, shows up in the recorded acknowledge order. A read error has to stop the channel with no write and no acknowledge. A design that carries on would corrupt the destination and re-grant the channel. Writes to the count and addresses of a running channel are checked by reading them back: an engine that accepts them would report the new values.

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [7:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           m_req,
  output logic           m_we,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic [DW-1:0]  m_rdata,
  input  logic           m_ack,
  input  logic           m_err,
  output logic           irq
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] STEP = AW'(4);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} state_t;
  state_t state;

  logic [NCH-1:0] en, dir, circ, pinc, minc, ie_d, ie_e, done_f, err_f;
  logic [1:0]     prio  [NCH];
  logic [CW-1:0]  cnt_b [NCH];
  logic [CW-1:0]  cnt_c [NCH];
  logic [AW-1:0]  pa_b  [NCH];
  logic [AW-1:0]  pa_c  [NCH];
  logic [AW-1:0]  ma_b  [NCH];
  logic [AW-1:0]  ma_c  [NCH];
  logic [CHW-1:0] cur;
  logic [DW-1:0]  hold;

  wire       is_glob = cfg_addr[7];
  wire [2:0] sel_ch  = cfg_addr[6:4];
  wire [1:0] sel_reg = cfg_addr[3:2];
  wire       clr_we  = cfg_we && is_glob && (cfg_addr[6:2] == 5'd1);

  always_comb begin
    cfg_rdata = '0;
    if (is_glob) begin
      if (cfg_addr[6:2] == 5'd0) begin
        cfg_rdata[NCH-1:0]  = done_f;
        cfg_rdata[8+:NCH]   = err_f;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (sel_ch == 3'(c)) begin
          case (sel_reg)
            2'd0: cfg_rdata = {23'd0, ie_e[c], ie_d[c], prio[c], minc[c], pinc[c], circ[c], dir[c], en[c]};
            2'd1: cfg_rdata = 32'(cnt_c[c]);
            2'd2: cfg_rdata = 32'(pa_c[c]);
            default: cfg_rdata = 32'(ma_c[c]);
          endcase
        end
      end
    end
  end

  logic           win_v;
  logic [CHW-1:0] win;
  logic [1:0]     best;
  always_comb begin
    win_v = 1'b0;
    win   = '0;
    best  = 2'd0;
    for (int c = 0; c < NCH; c++) begin
      if (en[c] && cnt_c[c] != '0 && dreq[c] && (!win_v || prio[c] > best)) begin
        win_v = 1'b1;
        win   = CHW'(c);
        best  = prio[c];
      end
    end
  end

  wire [AW-1:0] src_a = dir[cur] ? pa_c[cur] : ma_c[cur];
  wire [AW-1:0] dst_a = dir[cur] ? ma_c[cur] : pa_c[cur];

  assign m_req   = (state == S_RD) || (state == S_WR);
  assign m_we    = (state == S_WR);
  assign m_addr  = m_we ? dst_a : src_a;
  assign m_wdata = hold;
  assign irq     = |((done_f & ie_d) | (err_f & ie_e));

  always_comb begin
    dack = '0;
    if (state == S_FIN) dack[cur] = 1'b1;
  end

  wire xfer_ok  = (state == S_WR) && m_ack && !m_err;
  wire xfer_err = m_req && m_ack && m_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      hold  <= '0;
    end else begin
      case (state)
        S_IDLE: if (win_v) begin cur <= win; state <= S_RD; end
        S_RD: if (m_ack) begin
          if (m_err) state <= S_IDLE;
          else begin hold <= m_rdata; state <= S_WR; end
        end
        S_WR: if (m_ack) state <= m_err ? S_IDLE : S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0; dir <= '0; circ <= '0; pinc <= '0; minc <= '0;
      ie_d <= '0; ie_e <= '0; done_f <= '0; err_f <= '0;
      for (int c = 0; c < NCH; c++) begin
        prio[c] <= '0; cnt_b[c] <= '0; cnt_c[c] <= '0;
        pa_b[c] <= '0; pa_c[c] <= '0; ma_b[c] <= '0; ma_c[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (cfg_we && !is_glob && sel_ch == 3'(c)) begin
          case (sel_reg)
            2'd0: begin
              en[c]   <= cfg_wdata[0];
              dir[c]  <= cfg_wdata[1];
              circ[c] <= cfg_wdata[2];
              pinc[c] <= cfg_wdata[3];
              minc[c] <= cfg_wdata[4];
              prio[c] <= cfg_wdata[6:5];
              ie_d[c] <= cfg_wdata[7];
              ie_e[c] <= cfg_wdata[8];
            end
            2'd1: if (!en[c]) begin cnt_b[c] <= cfg_wdata[CW-1:0]; cnt_c[c] <= cfg_wdata[CW-1:0]; end
            2'd2: if (!en[c]) begin pa_b[c] <= AW'(cfg_wdata); pa_c[c] <= AW'(cfg_wdata); end
            default: if (!en[c]) begin ma_b[c] <= AW'(cfg_wdata); ma_c[c] <= AW'(cfg_wdata); end
          endcase
        end
        if (clr_we) begin
          done_f[c] <= done_f[c] & ~cfg_wdata[c];
          err_f[c]  <= err_f[c]  & ~cfg_wdata[8+c];
        end
        if (cur == CHW'(c)) begin
          if (xfer_err) begin
            en[c]    <= 1'b0;
            err_f[c] <= 1'b1;
          end
          if (xfer_ok) begin
            if (pinc[c]) pa_c[c] <= pa_c[c] + STEP;
            if (minc[c]) ma_c[c] <= ma_c[c] + STEP;
            cnt_c[c] <= cnt_c[c] - 1'b1;
            if (cnt_c[c] == CW'(1)) begin
              done_f[c] <= 1'b1;
              if (circ[c]) begin
                cnt_c[c] <= cnt_b[c];
                pa_c[c]  <= pa_b[c];
                ma_c[c]  <= ma_b[c];
              end else begin
                en[c] <= 1'b0;
              end
            end
          end
        end
      end
    end
  end

  // R10: a pending master request keeps its address and direction
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

  // R7: at most one acknowledge line at a time
  a_r7_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R7: an acknowledge only follows a completed, error-free write
  a_r7_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> $past(m_req && m_we && m_ack && !m_err));

  // R8: an error response is never followed by an acknowledge
  a_r8_err_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ack && m_err) |=> (dack == '0));

  // R8: a failed read is not followed by a write
  a_r8_rd_err_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we && m_ack && m_err) |=> !m_req);

  // R7: the engine leaves idle only for a requesting channel
  a_r7_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) |-> $past(|dreq));
endmodule

// File: tb/dma_xfer_ctrl_tb.sv
module dma_xfer_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NCH-1:0] dreq = '0;
  logic [NCH-1:0] dack;
  logic m_req, m_we;
  logic [31:0] m_addr, m_wdata;
  logic [31:0] m_rdata = '0;
  logic m_ack = 1'b0;
  logic m_err = 1'b0;
  logic irq;

  int tests = 0;
  int fails = 0;
  int nrd = 0;
  int nwr = 0;
  int log_ch [16];
  int nlog = 0;
  logic [31:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_ctrl #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .dack(dack),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err), .irq(irq)
  );

  always @(negedge clk) begin
    if (m_req && !m_ack) begin
      m_ack <= 1'b1;
      if (m_addr >= 32'h400) m_err <= 1'b1;
      else begin
        m_err <= 1'b0;
        if (m_we) begin mem[m_addr[9:2]] <= m_wdata; nwr <= nwr + 1; end
        else begin m_rdata <= mem[m_addr[9:2]]; nrd <= nrd + 1; end
      end
    end else begin
      m_ack <= 1'b0;
      m_err <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_we = 1'b0;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [7:0] ra(input int ch, input int r);
    return 8'((ch << 4) | (r << 2));
  endfunction

  task automatic run_reqs(input int n0, input int n1, input int n2, input int n3,
                          input int limit, output int acks);
    int left [4];
    left[0] = n0; left[1] = n1; left[2] = n2; left[3] = n3;
    acks = 0; nlog = 0;
    @(negedge clk);
    for (int c = 0; c < 4; c++) dreq[c] = (left[c] > 0);
    for (int k = 0; k < limit && dreq != '0; k++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        if (dack[c]) begin
          left[c]--; acks++;
          if (nlog < 16) begin log_ch[nlog] = c; nlog++; end
        end
        dreq[c] = (left[c] > 0);
      end
    end
    dreq = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(ra(0, 0), d); chk("R1 reset ctrl", d, 32'h0);
    rd(8'h80, d);    chk("R9 reset status", d, 32'h0);
    chk("R9 reset irq", 32'(irq), 32'h0);
    chk("R10 reset m_req", 32'(m_req), 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bit quiet;
    wr(ra(1, 1), 32'd5); wr(ra(1, 2), 32'h100); wr(ra(1, 3), 32'h200);
    wr(ra(1, 0), 32'h1F8);
    rd(ra(1, 0), d); chk("R1 ctrl readback", d, 32'h1F8);
    rd(ra(1, 1), d); chk("R1 count readback", d, 32'd5);
    wr(ra(1, 0), 32'h001);
    wr(ra(1, 1), 32'd9); wr(ra(1, 2), 32'h999); wr(ra(1, 3), 32'h777);
    rd(ra(1, 1), d); chk("R1 count write ignored when enabled", d, 32'd5);
    rd(ra(1, 2), d); chk("R1 paddr write ignored when enabled", d, 32'h100);
    rd(ra(1, 3), d); chk("R1 maddr write ignored when enabled", d, 32'h200);
    quiet = 1'b1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (m_req) quiet = 1'b0; end
    chk("R7 no activity without request", 32'(quiet), 32'h1);
    wr(ra(1, 0), 32'h0);
  endtask

  task automatic t_mem_to_periph;
    logic [31:0] d;
    int acks, r0, w0;
    mem[16] = 32'hA000_0001; mem[17] = 32'hA000_0002; mem[18] = 32'hA000_0003;
    mem[8'hC0] = 32'h0;
    wr(ra(0, 1), 32'd3); wr(ra(0, 2), 32'h300); wr(ra(0, 3), 32'h40);
    wr(ra(0, 0), 32'h011);
    r0 = nrd; w0 = nwr;
    run_reqs(3, 0, 0, 0, 200, acks);
    chk("R7 one ack per item", 32'(acks), 32'd3);
    chk("R10 one read per item", 32'(nrd - r0), 32'd3);
    chk("R10 one write per item", 32'(nwr - w0), 32'd3);
    chk("R2 dir0 last word at peripheral", mem[8'hC0], 32'hA000_0003);
    rd(ra(0, 3), d); chk("R3 memory address stepped", d, 32'h4C);
    rd(ra(0, 2), d); chk("R3 peripheral address fixed", d, 32'h300);
    rd(ra(0, 1), d); chk("R4 count reached zero", d, 32'd0);
    rd(ra(0, 0), d); chk("R4 enable cleared", d & 32'h1, 32'h0);
    rd(8'h80, d);    chk("R4 completion flag", d, 32'h1);
    chk("R9 irq off when not enabled", 32'(irq), 32'h0);
    wr(8'h84, 32'h1);
    rd(8'h80, d);    chk("R9 flag cleared", d, 32'h0);
  endtask

  task automatic t_periph_to_mem;
    logic [31:0] d;
    int acks;
    mem[8'h20] = 32'hB0B0_0001; mem[8'h21] = 32'hB0B0_0002;
    mem[8'h60] = 32'h0; mem[8'h61] = 32'h0;
    wr(ra(2, 1), 32'd2); wr(ra(2, 2), 32'h80); wr(ra(2, 3), 32'h180);
    wr(ra(2, 0), 32'h09B);
    run_reqs(0, 0, 2, 0, 200, acks);
    chk("R2 dir1 first word", mem[8'h60], 32'hB0B0_0001);
    chk("R2 dir1 second word", mem[8'h61], 32'hB0B0_0002);
    rd(ra(2, 2), d); chk("R3 peripheral address stepped", d, 32'h88);
    rd(8'h80, d);    chk("R9 status bit of channel 2", d, 32'h4);
    chk("R9 irq on completion", 32'(irq), 32'h1);
    wr(8'h84, 32'h4);
    rd(8'h80, d);    chk("R9 status after clear", d, 32'h0);
    chk("R9 irq after clear", 32'(irq), 32'h0);
  endtask

  task automatic t_circular;
    logic [31:0] d;
    int acks;
    mem[8'h08] = 32'hC1C1_0001;
    wr(ra(3, 1), 32'd2); wr(ra(3, 2), 32'h20); wr(ra(3, 3), 32'h1C0);
    wr(ra(3, 0), 32'h017);
    run_reqs(0, 0, 0, 2, 200, acks);
    rd(ra(3, 1), d); chk("R5 count reloaded", d, 32'd2);
    rd(ra(3, 3), d); chk("R5 memory address reloaded", d, 32'h1C0);
    rd(ra(3, 0), d); chk("R5 still enabled", d & 32'h1, 32'h1);
    rd(8'h80, d);    chk("R5 completion flag on wrap", d, 32'h8);
    mem[8'h08] = 32'hC1C1_0002;
    run_reqs(0, 0, 0, 1, 200, acks);
    chk("R5 write after wrap at base", mem[8'h70], 32'hC1C1_0002);
    rd(ra(3, 1), d); chk("R5 count after wrap", d, 32'd1);
    rd(ra(3, 3), d); chk("R5 address after wrap", d, 32'h1C4);
    wr(ra(3, 0), 32'h0);
    wr(8'h84, 32'hFFFF);
  endtask

  task automatic t_priority;
    int acks;
    mem[8'h90] = 32'h1; mem[8'h91] = 32'h2; mem[8'h92] = 32'h3;
    for (int c = 0; c < 3; c++) begin
      wr(ra(c, 1), 32'd1);
      wr(ra(c, 2), 32'h2C0 + 32'(4 * c));
      wr(ra(c, 3), 32'h240 + 32'(4 * c));
    end
    wr(ra(0, 0), 32'h021);
    wr(ra(1, 0), 32'h061);
    wr(ra(2, 0), 32'h061);
    run_reqs(1, 1, 1, 0, 300, acks);
    chk("R6 three grants", 32'(acks), 32'd3);
    chk("R6 first grant highest priority", 32'(log_ch[0]), 32'd1);
    chk("R6 tie goes to lower index", 32'(log_ch[1]), 32'd2);
    chk("R6 lowest priority last", 32'(log_ch[2]), 32'd0);
    wr(8'h84, 32'hFFFF);
  endtask

  task automatic t_error;
    logic [31:0] d;
    int acks, w0;
    wr(ra(0, 1), 32'd1); wr(ra(0, 2), 32'h300); wr(ra(0, 3), 32'h1000);
    wr(ra(0, 0), 32'h111);
    w0 = nwr;
    run_reqs(1, 0, 0, 0, 40, acks);
    chk("R8 no ack on error", 32'(acks), 32'd0);
    chk("R8 no write after read error", 32'(nwr - w0), 32'd0);
    rd(ra(0, 0), d); chk("R8 enable cleared", d & 32'h1, 32'h0);
    rd(ra(0, 1), d); chk("R8 count unchanged", d, 32'd1);
    rd(8'h80, d);    chk("R8 error flag", d, 32'h100);
    chk("R9 irq on error", 32'(irq), 32'h1);
    wr(8'h84, 32'h100);
    rd(8'h80, d);    chk("R9 error flag cleared", d, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_mem_to_periph;
    t_periph_to_mem;
    t_circular;
    t_priority;
    t_error;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule